// File: doc/BRIEF.md
# Vector Tail-Policy Configuration Register

This block holds the vector-type configuration word of a vector unit, limited to an element-width field, a length-multiplier field, a two-bit tail-policy field and an illegal-configuration flag. A configuration-update request carries a requested element width, a length multiplier and an optional tail-policy operand. The block checks the request and writes the word on the next clock edge. An illegal request leaves only the flag set.

A second, read-only word reports the tail behaviour that the implementation prefers. Consumers use it to resolve the "preferred" policy encoding. A build-time parameter selects whether tail zeroing is supported. A minimal build supports undisturbed tails only, and reports undisturbed as its preference.

Top module: `vtail_cfg_reg`

## Requirements
- R1: After reset, the configuration word reads all zeros. The tail-policy output is 00 and the illegal flag is 0.
- R2: A valid update with tail operand 00 (no operand) clears the flag and writes 00 into bits 9:8. It writes the width into bits 5:3 and the multiplier into bits 2:0. All other bits are zero.
- R3: A valid update with tail operand 01 (undisturbed) writes 01 into bits 9:8 and clears the flag.
- R4: When zeroing is supported (ZERO_EN=1), a valid update with tail operand 10 writes 10 into bits 9:8 and clears the flag.
- R5: When zeroing is not supported, a valid update with tail operand 10 sets the illegal flag.
- R6: A valid update with tail operand 11 (reserved encoding) sets the illegal flag in either build.
- R7: The illegal flag is bit XLEN-1 of the word. While it is set, every other bit reads zero. The next legal update clears it.
- R8: Without a valid update, the configuration word does not change, whatever the other request inputs do.
- R9: The preferred-policy word carries its code in bits 1:0, with all other bits zero. The code is 01 when zeroing is unsupported. It is 10 only when zeroing is supported and PREFER_ZERO=1.
- R10: An update is visible on the outputs right after the clock edge that samples the valid request, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_valid_i | input | 1 | Configuration-update request strobe |
| upd_sew_i | input | SEW_W (3) | Requested element-width code |
| upd_lmul_i | input | LMUL_W (3) | Requested length-multiplier code |
| upd_tail_i | input | 2 | Tail operand: 00 none, 01 undisturbed, 10 zeroing, 11 reserved |
| vtype_o | output | XLEN (32) | Current configuration word |
| tail_pol_o | output | 2 | Current tail-policy field (bits 9:8 of the word) |
| ill_o | output | 1 | Illegal-configuration flag |
| pref_o | output | XLEN (32) | Read-only preferred-policy word |

## Verification
The assertions check on every cycle that:
- the word holds when no update is requested;
- a set flag forces every other bit to zero;
- each tail operand leads one cycle later to the expected field value or to the flag, with the requested width and multiplier copied into a legal word.

The bench scenarios are needed for the rest:
- the reset value;
- the constant preferred-policy word in each build;
- that an update is not visible before its clock edge;
- that a legal update after an illegal one clears the flag;
- the contrast between the two builds for the same zeroing request.

// File: rtl/vtcfg_pkg.sv
package vtcfg_pkg;

  typedef enum logic [1:0] {
    TP_PREF = 2'b00,
    TP_UND  = 2'b01,
    TP_ZERO = 2'b10,
    TP_RSV  = 2'b11
  } tail_pol_e;

  localparam int unsigned TAIL_W   = 2;
  localparam int unsigned TAIL_LSB = 8;
  localparam int unsigned LMUL_LSB = 0;

endpackage

// File: rtl/vtcfg_legal.sv
module vtcfg_legal
  import vtcfg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned SEW_W   = 3,
  parameter int unsigned LMUL_W  = 3,
  parameter bit          ZERO_EN = 1'b0
) (
  input  logic [SEW_W-1:0]  req_sew_i,
  input  logic [LMUL_W-1:0] req_lmul_i,
  input  logic [TAIL_W-1:0] req_tail_i,
  output logic              illegal_o,
  output logic [XLEN-1:0]   nxt_vtype_o
);
  localparam int unsigned SEW_LSB = LMUL_LSB + LMUL_W;
  localparam int unsigned ILL_BIT = XLEN - 1;

  tail_pol_e req_pol;
  assign req_pol = tail_pol_e'(req_tail_i);

  always_comb begin
    illegal_o = 1'b0;
    case (req_pol)
      TP_ZERO: illegal_o = !ZERO_EN;
      TP_RSV:  illegal_o = 1'b1;
      default: illegal_o = 1'b0;
    endcase
  end

  // illegal word keeps only the flag
  always_comb begin
    nxt_vtype_o = '0;
    if (illegal_o) begin
      nxt_vtype_o[ILL_BIT] = 1'b1;
    end else begin
      nxt_vtype_o[TAIL_LSB +: TAIL_W] = req_tail_i;
      nxt_vtype_o[SEW_LSB  +: SEW_W]  = req_sew_i;
      nxt_vtype_o[LMUL_LSB +: LMUL_W] = req_lmul_i;
    end
  end

endmodule

// File: rtl/vtcfg_state.sv
module vtcfg_state #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_valid_i,
  input  logic [XLEN-1:0] nxt_vtype_i,
  output logic [XLEN-1:0] vtype_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vtype_q_o <= '0;
    else if (upd_valid_i) vtype_q_o <= nxt_vtype_i;
  end

  a_r8_hold_without_update: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(vtype_q_o));

endmodule

// File: rtl/vtcfg_pref.sv
module vtcfg_pref
  import vtcfg_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter bit          ZERO_EN     = 1'b0,
  parameter bit          PREFER_ZERO = 1'b0
) (
  output logic [XLEN-1:0] pref_o
);
  logic [TAIL_W-1:0] code;

  // zeroing may only be preferred where it exists
  if (ZERO_EN && PREFER_ZERO) begin : g_pref_zero
    assign code = TP_ZERO;
  end else begin : g_pref_und
    assign code = TP_UND;
  end

  assign pref_o = {{(XLEN-TAIL_W){1'b0}}, code};

endmodule

// File: rtl/vtail_cfg_reg.sv
module vtail_cfg_reg
  import vtcfg_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned SEW_W       = 3,
  parameter int unsigned LMUL_W      = 3,
  parameter bit          ZERO_EN     = 1'b0,
  parameter bit          PREFER_ZERO = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [SEW_W-1:0]  upd_sew_i,
  input  logic [LMUL_W-1:0] upd_lmul_i,
  input  logic [1:0]        upd_tail_i,
  output logic [XLEN-1:0]   vtype_o,
  output logic [1:0]        tail_pol_o,
  output logic              ill_o,
  output logic [XLEN-1:0]   pref_o
);
  localparam int unsigned SEW_LSB = LMUL_LSB + LMUL_W;
  localparam int unsigned ILL_BIT = XLEN - 1;

  logic            req_illegal;
  logic [XLEN-1:0] nxt_vtype;
  logic [XLEN-1:0] vtype_q;

  vtcfg_legal #(
    .XLEN(XLEN), .SEW_W(SEW_W), .LMUL_W(LMUL_W), .ZERO_EN(ZERO_EN)
  ) u_legal (
    .req_sew_i  (upd_sew_i),
    .req_lmul_i (upd_lmul_i),
    .req_tail_i (upd_tail_i),
    .illegal_o  (req_illegal),
    .nxt_vtype_o(nxt_vtype)
  );

  vtcfg_state #(.XLEN(XLEN)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_valid_i(upd_valid_i),
    .nxt_vtype_i(nxt_vtype),
    .vtype_q_o  (vtype_q)
  );

  vtcfg_pref #(
    .XLEN(XLEN), .ZERO_EN(ZERO_EN), .PREFER_ZERO(PREFER_ZERO)
  ) u_pref (
    .pref_o(pref_o)
  );

  assign vtype_o    = vtype_q;
  assign tail_pol_o = vtype_q[TAIL_LSB +: TAIL_W];
  assign ill_o      = vtype_q[ILL_BIT];

  a_r7_ill_clears_fields: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    ill_o |-> (vtype_o[ILL_BIT-1:0] == '0));

  a_r2_none_writes_pref: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_tail_i == 2'b00) |=>
      (tail_pol_o == 2'b00 && !ill_o &&
       vtype_o[SEW_LSB +: SEW_W] == $past(upd_sew_i) &&
       vtype_o[LMUL_LSB +: LMUL_W] == $past(upd_lmul_i)));

  a_r3_undisturbed: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_tail_i == 2'b01) |=> (tail_pol_o == 2'b01 && !ill_o));

  a_r4_zero_supported: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_tail_i == 2'b10 && ZERO_EN) |=>
      (tail_pol_o == 2'b10 && !ill_o));

  a_r5_zero_unsupported: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_tail_i == 2'b10 && !ZERO_EN) |=> ill_o);

  a_r6_reserved_illegal: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_tail_i == 2'b11) |=> ill_o);

  a_r7_legal_clears_flag: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && ill_o && !req_illegal) |=> !ill_o);

endmodule

// File: tb/vtail_cfg_reg_bench.sv
module vtail_cfg_reg_bench;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_valid = 1'b0;
  logic [2:0] upd_sew = '0;
  logic [2:0] upd_lmul = '0;
  logic [1:0] upd_tail = '0;

  logic [XLEN-1:0] vt_m, pref_m, vt_z, pref_z;
  logic [1:0] tp_m, tp_z;
  logic ill_m, ill_z;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vtail_cfg_reg u_vtail_cfg_reg (
    .clk_i(clk), .rst_ni(rst_ni), .upd_valid_i(upd_valid),
    .upd_sew_i(upd_sew), .upd_lmul_i(upd_lmul), .upd_tail_i(upd_tail),
    .vtype_o(vt_m), .tail_pol_o(tp_m), .ill_o(ill_m), .pref_o(pref_m));

  vtail_cfg_reg #(.ZERO_EN(1'b1), .PREFER_ZERO(1'b1)) u_vtail_cfg_reg_z (
    .clk_i(clk), .rst_ni(rst_ni), .upd_valid_i(upd_valid),
    .upd_sew_i(upd_sew), .upd_lmul_i(upd_lmul), .upd_tail_i(upd_tail),
    .vtype_o(vt_z), .tail_pol_o(tp_z), .ill_o(ill_z), .pref_o(pref_z));

  function automatic logic [XLEN-1:0] exp_vt(bit zen, logic [2:0] s,
                                             logic [2:0] l, logic [1:0] t);
    if (t == 2'b11 || (t == 2'b10 && !zen)) return 32'h8000_0000;
    return {22'b0, t, 2'b00, s, l};
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, edge samples, read back at next negedge
  task automatic do_upd(logic [2:0] s, logic [2:0] l, logic [1:0] t);
    @(negedge clk);
    upd_valid = 1'b1; upd_sew = s; upd_lmul = l; upd_tail = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 vtype min", vt_m, '0);
    chk("R1 vtype zero", vt_z, '0);
    chk("R1 tail", {30'b0, tp_m}, 32'd0);
    chk("R1 ill", {31'b0, ill_z}, 32'd0);
    chk("R9 pref min", pref_m, 32'h1);
    chk("R9 pref zero build", pref_z, 32'h2);
  endtask

  task automatic t_none;
    do_upd(3'd3, 3'd1, 2'b00);
    chk("R2 min", vt_m, exp_vt(0, 3'd3, 3'd1, 2'b00));
    chk("R2 zero build", vt_z, exp_vt(1, 3'd3, 3'd1, 2'b00));
  endtask

  task automatic t_undist;
    do_upd(3'd2, 3'd7, 2'b01);
    chk("R3 min", vt_m, exp_vt(0, 3'd2, 3'd7, 2'b01));
    chk("R3 tail out", {30'b0, tp_z}, 32'd1);
  endtask

  task automatic t_zero;
    do_upd(3'd5, 3'd2, 2'b10);
    chk("R4 zero build", vt_z, exp_vt(1, 3'd5, 3'd2, 2'b10));
    chk("R5 min ill word", vt_m, 32'h8000_0000);
    chk("R5 ill out", {31'b0, ill_m}, 32'd1);
    do_upd(3'd1, 3'd0, 2'b01);
    chk("R7 legal clears", vt_m, exp_vt(0, 3'd1, 3'd0, 2'b01));
  endtask

  task automatic t_reserved;
    do_upd(3'd7, 3'd7, 2'b11);
    chk("R6 min", vt_m, 32'h8000_0000);
    chk("R6 zero build", vt_z, 32'h8000_0000);
    do_upd(3'd4, 3'd3, 2'b00);
    chk("R7 clear after rsv", vt_z, exp_vt(1, 3'd4, 3'd3, 2'b00));
    chk("R7 ill out", {31'b0, ill_z}, 32'd0);
  endtask

  task automatic t_hold;
    do_upd(3'd6, 3'd5, 2'b01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      upd_sew = 3'(i); upd_lmul = 3'(7 - i); upd_tail = 2'(i);
    end
    @(negedge clk);
    chk("R8 hold min", vt_m, exp_vt(0, 3'd6, 3'd5, 2'b01));
    chk("R8 hold zero build", vt_z, exp_vt(1, 3'd6, 3'd5, 2'b01));
  endtask

  task automatic t_timing;
    @(negedge clk);
    upd_valid = 1'b1; upd_sew = 3'd2; upd_lmul = 3'd2; upd_tail = 2'b10;
    @(posedge clk);
    #1;
    chk("R10 after edge", vt_z, exp_vt(1, 3'd2, 3'd2, 2'b10));
    upd_valid = 1'b0;
    @(negedge clk);
    upd_valid = 1'b1; upd_tail = 2'b01;
    #1;
    chk("R10 not before edge", vt_z, exp_vt(1, 3'd2, 3'd2, 2'b10));
    @(negedge clk);
    upd_valid = 1'b0;
    chk("R10 next update", vt_z, exp_vt(1, 3'd2, 3'd2, 2'b01));
    chk("R9 pref stays", pref_m, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_none;
    t_undist;
    t_zero;
    t_reserved;
    t_hold;
    t_timing;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule